// File: doc/BRIEF.md
# Multiplexed Byte-Bus Register Slave

This block is a small register file that a host reaches over one 8-bit bidirectional bus. The same lines carry the register index and the data. A separate select input marks a bus cycle as an index cycle. Every access takes two bus cycles. In the first, with the select input high, the host writes the index of the register it wants. In the second, with the select input low, it reads or writes that register. The index stays latched, so any number of data cycles can follow one index cycle. Chip select, the write strobe and the read strobe are all active low. The block completes each cycle by pulling its active-low ready output.

The map holds an interrupt control register, two bus control registers, a pair of card-access address bytes and a data byte, a pair of filter-table address bytes and a data byte, two stream clock dividers, and a read-only revision byte. The block keeps the contents of every register and hands them to the downstream units as one flat vector. It decodes two fields of the second bus control register directly: the stream output enables and the per-tuner reset lines, which are active low. An event input from the downstream logic raises a pending flag. The flag drives an active-low interrupt line once the host has armed it, and a read of the interrupt control register acknowledges it.

Top module: `muxbus_regslave`

## Requirements
- R1: A write-strobe cycle with the select input high latches the full bus byte as the register index. Every later data cycle uses that index until the next index cycle, so two data writes after one index cycle land in the same register.
- R2: When the block samples chip select low together with a write or read strobe low on a clock edge, ready falls in the following clock. A strobe with chip select high is never answered.
- R3: Ready returns high in the clock after the block samples both strobes high, or chip select high.
- R4: The block drives the bus only while chip select and the read strobe are low, the write strobe is high and the select input is low. In every other bus state it leaves the bus undriven.
- R5: The registers at indices 0x01, 0x04 to 0x0A, 0x0C and 0x0D read back the last value written to them. Each is 0x00 after reset.
- R6: Index 0x0F reads as the REVISION parameter (default 0x3C), and writes to it are ignored.
- R7: Any other index reads 0x00 and writes to it change nothing. This includes indices above 0x0F, which never alias to a lower register.
- R8: A one-clock pulse on evt_in sets a pending flag. irq_n is low exactly when, in the previous clock, the flag was set and index 0x00 held the arm code 0x44. Any other value in index 0x00 keeps irq_n high.
- R9: A data read of index 0x00 returns the pending flag in bit 0, with the other bits 0, and clears the flag. An evt_in pulse in the same clock as that read leaves the flag set.
- R10: ts_out_en follows bits 5:4 and tuner_rst_n follows bits 3:2 of index 0x01. After reset both are 0, so the tuners start held in reset.
- R11: During and after reset, ready and irq_n are high and every stored register is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_idx_sel | input | 1 | High marks an index cycle, low a data cycle |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_data | inout | 8 | Shared index/data lines |
| bus_rdy_n | output | 1 | Cycle complete, active low |
| evt_in | input | 1 | Interrupt event pulse from downstream logic |
| irq_n | output | 1 | Interrupt to the host, active low |
| ts_out_en | output | 2 | Stream output enables |
| tuner_rst_n | output | 2 | Per-tuner reset, active low |
| cfg_flat | output | 128 | Stored register bytes, byte n at bits 8n+7:8n |

## Verification
The case hardest to reach from the ports is an event that arrives in the very clock where the block accepts a read of index 0x00. In that clock the acknowledge and the new event compete for the pending flag. The bench raises evt_in on the same falling edge that lowers the read strobe, so the two share one sampling edge. It then expects the read to return 1 and the interrupt to stay asserted. A second situation is a stale read byte held inside while the bus must stay undriven. To expose any unwanted drive, the bench first reads back a nonzero value and then drives zero itself during index reads and deselected strobes.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  localparam int BUS_W = 8;

  localparam logic [BUS_W-1:0] IX_IRQ_CTL  = 8'h00;
  localparam logic [BUS_W-1:0] IX_BUS_CTL2 = 8'h01;
  localparam logic [BUS_W-1:0] IX_REV      = 8'h0F;

  typedef enum logic {HS_IDLE, HS_HELD} hs_state_e;

  function automatic logic idx_writable(input logic [BUS_W-1:0] a);
    case (a)
      8'h00, 8'h01, 8'h04, 8'h05, 8'h06, 8'h07,
      8'h08, 8'h09, 8'h0A, 8'h0C, 8'h0D: idx_writable = 1'b1;
      default:                           idx_writable = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/muxbus_handshake.sv
module muxbus_handshake
  import muxbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic idx_sel,
  input  logic wr_n,
  input  logic rd_n,
  output logic rdy_n,
  output logic idx_wr_stb,
  output logic data_wr_stb,
  output logic data_rd_stb,
  output logic drive_en
);

  hs_state_e st_q;
  logic      rdy_n_q;
  logic      take;
  logic      release_c;

  assign take      = (st_q == HS_IDLE) && !cs_n && (!wr_n || !rd_n);
  assign release_c = cs_n || (wr_n && rd_n);

  assign idx_wr_stb  = take && !wr_n && idx_sel;
  assign data_wr_stb = take && !wr_n && !idx_sel;
  assign data_rd_stb = take && wr_n && !rd_n && !idx_sel;
  assign drive_en    = !cs_n && !rd_n && wr_n && !idx_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= HS_IDLE;
      rdy_n_q <= 1'b1;
    end else begin
      case (st_q)
        HS_IDLE: if (take) begin
          st_q    <= HS_HELD;
          rdy_n_q <= 1'b0;
        end
        HS_HELD: if (release_c) begin
          st_q    <= HS_IDLE;
          rdy_n_q <= 1'b1;
        end
        default: begin
          st_q    <= HS_IDLE;
          rdy_n_q <= 1'b1;
        end
      endcase
    end
  end

  assign rdy_n = rdy_n_q;

  AST_RDY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n) |-> $past(!cs_n && !(wr_n && rd_n))); // R2

  AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!rdy_n && wr_n && rd_n) |=> rdy_n); // R3

endmodule

// File: rtl/muxbus_regbank.sv
module muxbus_regbank
  import muxbus_pkg::*;
#(
  parameter int               REG_COUNT = 16,
  parameter logic [BUS_W-1:0] REVISION  = 8'h3C
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   idx_wr_stb,
  input  logic                   data_wr_stb,
  input  logic                   data_rd_stb,
  input  logic [BUS_W-1:0]       din,
  input  logic                   pending,
  output logic [BUS_W-1:0]       rd_q,
  output logic                   ack_stb,
  output logic [BUS_W-1:0]       irq_ctl,
  output logic [REG_COUNT*8-1:0] cfg_flat
);

  localparam int IDX_W = $clog2(REG_COUNT);

  logic [BUS_W-1:0]       idx_q;
  logic [REG_COUNT*8-1:0] store_q;
  logic                   wr_ok;
  logic                   in_range;
  logic [BUS_W-1:0]       rd_val;

  assign in_range = (idx_q < BUS_W'(REG_COUNT));
  assign wr_ok    = data_wr_stb && in_range && idx_writable(idx_q);
  assign ack_stb  = data_rd_stb && (idx_q == IX_IRQ_CTL);

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (idx_wr_stb) idx_q <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) store_q <= '0;
    else if (wr_ok) store_q[idx_q[IDX_W-1:0]*8 +: 8] <= din;
  end

  always_comb begin
    if (idx_q == IX_IRQ_CTL)    rd_val = {7'b0, pending};
    else if (idx_q == IX_REV)   rd_val = REVISION;
    else if (in_range && idx_writable(idx_q))
      rd_val = store_q[idx_q[IDX_W-1:0]*8 +: 8];
    else                        rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (data_rd_stb) rd_q <= rd_val;
  end

  assign irq_ctl  = store_q[7:0];
  assign cfg_flat = store_q;

  AST_REV_READ: assert property (@(posedge clk) disable iff (rst)
    (data_rd_stb && idx_q == IX_REV) |=> (rd_q == REVISION)); // R6

  AST_UNMAPPED_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    (data_wr_stb && !idx_writable(idx_q)) |=> $stable(cfg_flat)); // R7

endmodule

// File: rtl/muxbus_irq.sv
module muxbus_irq
  import muxbus_pkg::*;
#(
  parameter logic [BUS_W-1:0] ARM_CODE = 8'h44
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_in,
  input  logic             ack_stb,
  input  logic [BUS_W-1:0] irq_ctl,
  output logic             pending,
  output logic             irq_n
);

  logic pend_q;
  logic irq_n_q;
  logic armed;

  assign armed = (irq_ctl == ARM_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      if (evt_in)       pend_q <= 1'b1;
      else if (ack_stb) pend_q <= 1'b0;
      irq_n_q <= ~(pend_q & armed);
    end
  end

  assign pending = pend_q;
  assign irq_n   = irq_n_q;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && !evt_in) |=> !pending); // R9

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    evt_in |=> pending); // R9

  AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(irq_ctl == ARM_CODE)); // R8

endmodule

// File: rtl/muxbus_regslave.sv
module muxbus_regslave
  import muxbus_pkg::*;
#(
  parameter int               REG_COUNT = 16,
  parameter logic [BUS_W-1:0] REVISION  = 8'h3C,
  parameter logic [BUS_W-1:0] ARM_CODE  = 8'h44
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_cs_n,
  input  logic                   bus_idx_sel,
  input  logic                   bus_wr_n,
  input  logic                   bus_rd_n,
  inout  wire  [BUS_W-1:0]       bus_data,
  output logic                   bus_rdy_n,
  input  logic                   evt_in,
  output logic                   irq_n,
  output logic [1:0]             ts_out_en,
  output logic [1:0]             tuner_rst_n,
  output logic [REG_COUNT*8-1:0] cfg_flat
);

  logic             idx_wr_stb;
  logic             data_wr_stb;
  logic             data_rd_stb;
  logic             drive_en;
  logic             ack_stb;
  logic             pending;
  logic [BUS_W-1:0] rd_q;
  logic [BUS_W-1:0] irq_ctl;

  muxbus_handshake u_hs (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (bus_cs_n),
    .idx_sel    (bus_idx_sel),
    .wr_n       (bus_wr_n),
    .rd_n       (bus_rd_n),
    .rdy_n      (bus_rdy_n),
    .idx_wr_stb (idx_wr_stb),
    .data_wr_stb(data_wr_stb),
    .data_rd_stb(data_rd_stb),
    .drive_en   (drive_en)
  );

  muxbus_regbank #(
    .REG_COUNT(REG_COUNT),
    .REVISION (REVISION)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .idx_wr_stb (idx_wr_stb),
    .data_wr_stb(data_wr_stb),
    .data_rd_stb(data_rd_stb),
    .din        (bus_data),
    .pending    (pending),
    .rd_q       (rd_q),
    .ack_stb    (ack_stb),
    .irq_ctl    (irq_ctl),
    .cfg_flat   (cfg_flat)
  );

  muxbus_irq #(
    .ARM_CODE(ARM_CODE)
  ) u_irq (
    .clk    (clk),
    .rst    (rst),
    .evt_in (evt_in),
    .ack_stb(ack_stb),
    .irq_ctl(irq_ctl),
    .pending(pending),
    .irq_n  (irq_n)
  );

  assign bus_data    = drive_en ? rd_q : {BUS_W{1'bz}};
  assign ts_out_en   = cfg_flat[IX_BUS_CTL2*8+4 +: 2];
  assign tuner_rst_n = cfg_flat[IX_BUS_CTL2*8+2 +: 2];

endmodule

// File: tb/test_muxbus_regslave.sv
module test_muxbus_regslave;

  localparam int       NREG = 16;
  localparam bit [7:0] REV  = 8'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, idx_sel = 1'b0, wr_n = 1'b1, rd_n = 1'b1, evt = 1'b0;
  logic host_oe = 1'b0;
  logic [7:0] host_dat = 8'h00;
  wire  [7:0] bus_data;
  logic rdy_n, irq_n;
  logic [1:0] ts_out_en, tuner_rst_n;
  logic [NREG*8-1:0] cfg_flat;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign bus_data = host_oe ? host_dat : 8'hzz;

  muxbus_regslave i_muxbus_regslave (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_idx_sel(idx_sel),
    .bus_wr_n(wr_n), .bus_rd_n(rd_n), .bus_data(bus_data),
    .bus_rdy_n(rdy_n), .evt_in(evt), .irq_n(irq_n),
    .ts_out_en(ts_out_en), .tuner_rst_n(tuner_rst_n), .cfg_flat(cfg_flat)
  );

  // behavioural reference model
  bit [7:0] m_regs [NREG];
  bit [7:0] m_idx;
  bit m_busy, m_pend, m_irq_n;

  function automatic bit m_wr_ok(input bit [7:0] a);
    return (a < 8'h10) && (a != 8'h02) && (a != 8'h03) && (a != 8'h0B)
           && (a != 8'h0E) && (a != 8'h0F);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_regs[i]) m_regs[i] = 8'h00;
      m_idx = 0; m_busy = 0; m_pend = 0; m_irq_n = 1;
    end else begin
      bit acc, ack, armed;
      acc   = !m_busy && !cs_n && (!wr_n || !rd_n);
      armed = (m_regs[0] == 8'h44);
      ack   = acc && wr_n && !rd_n && !idx_sel && (m_idx == 8'h00);
      m_irq_n = !(m_pend && armed);
      if (acc && !wr_n) begin
        if (idx_sel) m_idx = host_dat;
        else if (m_wr_ok(m_idx)) m_regs[m_idx[3:0]] = host_dat;
      end
      if (evt) m_pend = 1;
      else if (ack) m_pend = 0;
      if (acc) m_busy = 1;
      else if (m_busy && (cs_n || (wr_n && rd_n))) m_busy = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison with the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NREG*8-1:0] ecfg;
      for (int i = 0; i < NREG; i++) ecfg[i*8 +: 8] = m_regs[i];
      check(rdy_n === !m_busy, "R2/R3 rdy_n", 128'(rdy_n), 128'(!m_busy));
      check(irq_n === m_irq_n, "R8 irq_n", 128'(irq_n), 128'(m_irq_n));
      check(cfg_flat === ecfg, "R5/R7 cfg_flat", cfg_flat, ecfg);
      check(ts_out_en === m_regs[1][5:4], "R10 ts_out_en", 128'(ts_out_en),
            128'(m_regs[1][5:4]));
      check(tuner_rst_n === m_regs[1][3:2], "R10 tuner_rst_n", 128'(tuner_rst_n),
            128'(m_regs[1][3:2]));
    end
  end

  task automatic wait_rdy(input logic lvl);
    for (int k = 0; k < 20 && rdy_n !== lvl; k++) @(negedge clk);
  endtask

  task automatic cyc_write(input bit is_idx, input bit [7:0] v);
    @(negedge clk);
    cs_n = 0; idx_sel = is_idx; host_oe = 1; host_dat = v; wr_n = 0;
    @(negedge clk);
    wait_rdy(1'b0);
    wr_n = 1; cs_n = 1; host_oe = 0;
    @(negedge clk);
    check(rdy_n === 1'b1, "R3 release", 128'(rdy_n), 128'(1));
  endtask

  task automatic data_read(input bit [7:0] exp, input string tag, input bit ev);
    @(negedge clk);
    cs_n = 0; idx_sel = 0; rd_n = 0; evt = ev;
    @(negedge clk);
    evt = 0;
    check(rdy_n === 1'b0, "R2 ready", 128'(rdy_n), 128'(0));
    wait_rdy(1'b0);
    check(bus_data === exp, tag, 128'(bus_data), 128'(exp));
    rd_n = 1; cs_n = 1;
    @(negedge clk);
  endtask

  task automatic reg_read(input bit [7:0] ix, input bit [7:0] exp, input string tag);
    cyc_write(1, ix);
    data_read(exp, tag, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog R2 act=%0d exp=%0d", cyc, 50000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(rdy_n === 1 && irq_n === 1, "R11 reset outputs", 128'({rdy_n, irq_n}), 128'(3));
    check(cfg_flat === '0, "R11 reset regs", cfg_flat, 0);
    rst = 0;
    @(negedge clk);
    check(tuner_rst_n === 2'b00, "R10 tuners held", 128'(tuner_rst_n), 0);

    // R5: write/read every writable register
    for (int a = 0; a < 16; a++) begin
      if (m_wr_ok(8'(a)) && a != 0) begin
        cyc_write(1, 8'(a));
        cyc_write(0, 8'(8'h11 * a + 8'h5));
      end
    end
    for (int a = 1; a < 16; a++)
      if (m_wr_ok(8'(a))) reg_read(8'(a), 8'(8'h11 * a + 8'h5), "R5 readback");

    // R1: one index cycle, two data writes, read lands in same register
    cyc_write(1, 8'h0C);
    cyc_write(0, 8'h9A);
    cyc_write(0, 8'hC3);
    data_read(8'hC3, "R1 latched index", 0);
    data_read(8'hC3, "R1 index persists", 0);

    // R4: stale 0xC3 inside; host drives 0 where block must not drive
    @(negedge clk);
    host_oe = 1; host_dat = 8'h00; cs_n = 1; rd_n = 0;
    @(negedge clk);
    check(bus_data === 8'h00, "R4 deselected", 128'(bus_data), 0);
    repeat (2) @(negedge clk);
    check(rdy_n === 1'b1, "R2 no ready without cs", 128'(rdy_n), 1);
    cs_n = 0; idx_sel = 1;
    @(negedge clk);
    check(bus_data === 8'h00, "R4 index read", 128'(bus_data), 0);
    rd_n = 1; cs_n = 1; idx_sel = 0; host_oe = 0;
    repeat (2) @(negedge clk);

    // R6 revision
    reg_read(8'h0F, REV, "R6 revision");
    cyc_write(0, 8'hFF);
    data_read(REV, "R6 revision after write", 0);

    // R7 unmapped
    cyc_write(1, 8'h02); cyc_write(0, 8'h77);
    data_read(8'h00, "R7 unmapped read", 0);
    cyc_write(1, 8'h14); cyc_write(0, 8'h66);
    data_read(8'h00, "R7 high index read", 0);
    reg_read(8'h04, 8'h49, "R7 no alias");

    // R10 field decode
    cyc_write(1, 8'h01); cyc_write(0, 8'h2C);
    check(ts_out_en === 2'b10 && tuner_rst_n === 2'b11, "R10 decode",
          128'({ts_out_en, tuner_rst_n}), 128'(4'b1011));

    // R8 interrupt arming
    @(negedge clk); evt = 1; @(negedge clk); evt = 0;
    repeat (3) @(negedge clk);
    check(irq_n === 1'b1, "R8 unarmed", 128'(irq_n), 1);
    cyc_write(1, 8'h00); cyc_write(0, 8'h44);
    @(negedge clk);
    check(irq_n === 1'b0, "R8 armed", 128'(irq_n), 0);
    cyc_write(0, 8'h45);
    @(negedge clk);
    check(irq_n === 1'b1, "R8 wrong code", 128'(irq_n), 1);
    cyc_write(0, 8'h44);

    // R9 acknowledge and coincident event
    data_read(8'h01, "R9 pending read", 0);
    @(negedge clk);
    check(irq_n === 1'b1, "R9 acked", 128'(irq_n), 1);
    data_read(8'h00, "R9 cleared", 0);
    @(negedge clk); evt = 1; @(negedge clk); evt = 0;
    data_read(8'h01, "R9 read with event", 1);
    @(negedge clk);
    check(irq_n === 1'b0, "R9 event wins", 128'(irq_n), 0);
    data_read(8'h01, "R9 still pending", 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule